// File: doc/BRIEF.md
# Oversampled Serial Bit Recovery

This block sits behind a fixed-frequency sampler that takes roughly five samples of a serial line for each data bit. Every cycle of the parallel clock it receives one group of ten raw samples (two nominal bit periods), marks where the line changed level, and from those marks works out which sample position lies farthest from the bit edges. It keeps one sample per bit at that position and packs the kept bits into 10-bit words, raising a one-cycle valid strobe for each finished word.

The phase choice keeps adapting. Edge positions are counted over a window of sixteen groups, and at the end of each window the sampling position moves at most one sample toward the centre of the dominant edge position. When the position steps across the group boundary, that group yields one bit fewer or one bit more than the nominal two. This lets the block follow a small rate difference between sampler and line without a recovered clock. A small accumulator absorbs the uneven bit counts, so words come out whole. Word boundaries are not aligned to any framing.

Acquisition runs through three states. HUNT waits for a group that holds an edge (HUNT to ARM). ARM needs an edge in the very next group (ARM to TRACK, which fixes the initial phase from the earliest edge in that group); a group without an edge sends it back (ARM to HUNT). TRACK recovers bits and is left only by reset.

Top module: `osr_bit_recovery`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rx_word_valid_o` is low, `rx_word_o` is zero and the block is in HUNT.
- R2: No word is emitted until two consecutive sample groups each contain an edge. A group with an edge followed by a group without one returns the block to HUNT, and nothing is emitted outside TRACK.
- R3: An edge at group index i means sample i differs from the sample just before it. For index 0 that is the last sample (index 9) of the previous group, so a level change exactly on the group boundary counts as an edge.
- R4: On entering TRACK the sampling phase is set to (index of the earliest edge in the locking group + 2) mod 5. In a nominal group the kept bits are the samples at indices phase and phase+5, in that order.
- R5: In TRACK, edges are counted per position mod 5 over windows of 16 groups. At each window end the dominant position (the lowest on a tie) gives a target of dominant+2 mod 5. The phase moves exactly one position toward the target along the shorter way round and never changes by more than one position per window.
- R6: When the phase steps from 4 to 0, the next group yields a single bit (index 5). When it steps from 0 to 4, the next group yields three bits: the last sample of the previous group, then indices 4 and 9.
- R7: Kept bits are packed with the earliest bit in word bit 0. `rx_word_valid_o` is a one-cycle pulse in the cycle after the group that completes ten bits, and surplus bits carry into the next word.
- R8: With a line-rate offset of up to ±200 ppm and random edge jitter of up to ±0.4 sample, the recovered stream equals the transmitted stream with no lost, repeated or flipped bits.
- R9: In TRACK, consecutive word pulses are between 4 and 6 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_samples_i | input | 10 | Raw sample group, index 0 earliest |
| rx_word_o | output | 10 | Recovered word, earliest bit in bit 0 |
| rx_word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The hardest condition to reach from the ports is the phase crossing the group boundary, which produces the one-bit and three-bit groups. It occurs only after the sampling point has drifted a full five samples. The stimulus therefore models the line in fine time steps with a rate offset of ±200 ppm, long enough for two crossings per run, and adds random edge jitter. It sends a maximal-length pseudo-random sequence, which a self-synchronising predictor in the bench checks bit by bit. The lock phase is swept over all ten edge positions with a marker pattern that yields a known word only if the expected sample index is kept.

// File: rtl/osr_pkg.sv
package osr_pkg;

    // Acquisition progress of the recovery block.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARM   = 2'd1,
        ST_TRACK = 2'd2
    } acq_state_t;

    // Direction of the most recent sampling-phase move (valid for one cycle).
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_t;

endpackage

// File: rtl/osr_edge_detect.sv
module osr_edge_detect #(
    parameter int GROUP = 10,
    localparam int IDX_W = $clog2(GROUP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GROUP-1:0] samp_i,
    output logic [GROUP-1:0] edges_o,
    output logic             any_edge_o,
    output logic [IDX_W-1:0] first_idx_o,
    output logic             prev_last_o
);

    logic last_q;

    // Keep the final sample so edges across the group seam are seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= samp_i[GROUP-1];
        end
    end

    assign edges_o[0] = samp_i[0] ^ last_q;

    generate
        for (genvar gi = 1; gi < GROUP; gi++) begin : g_xor
            assign edges_o[gi] = samp_i[gi] ^ samp_i[gi-1];
        end
    endgenerate

    always_comb begin
        first_idx_o = '0;
        for (int i = GROUP - 1; i >= 0; i--) begin
            if (edges_o[i]) begin
                first_idx_o = IDX_W'(i);
            end
        end
    end

    assign any_edge_o  = |edges_o;
    assign prev_last_o = last_q;

endmodule

// File: rtl/osr_phase_track.sv
module osr_phase_track
    import osr_pkg::*;
#(
    parameter int OSR      = 5,
    parameter int BITS_NOM = 2,
    parameter int WINDOW   = 16,
    localparam int GROUP = OSR * BITS_NOM,
    localparam int IDX_W = $clog2(GROUP),
    localparam int PH_W  = $clog2(OSR),
    localparam int CNT_W = $clog2(WINDOW * BITS_NOM + 1),
    localparam int WIN_W = $clog2(WINDOW),
    localparam int HALF  = OSR / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             snap_i,
    input  logic [IDX_W-1:0] snap_idx_i,
    input  logic [GROUP-1:0] edges_i,
    output logic [PH_W-1:0]  phase_o,
    output step_t            step_o
);

    logic [CNT_W-1:0] cnt_q [OSR];
    logic [CNT_W-1:0] hits  [OSR];
    logic [CNT_W-1:0] tot   [OSR];
    logic [WIN_W-1:0] wcnt_q;
    logic [PH_W-1:0]  phase_q;
    step_t            step_q;

    logic [PH_W-1:0]  best;
    logic [CNT_W-1:0] best_cnt;
    logic             have_edges;
    logic             move_up;
    logic             move_dn;
    logic [PH_W-1:0]  phase_inc;
    logic [PH_W-1:0]  phase_dec;
    logic [PH_W-1:0]  snap_phase;
    int               target;
    int               diff;

    // Edge histogram for this group merged with the running window count.
    always_comb begin
        for (int p = 0; p < OSR; p++) begin
            hits[p] = '0;
            for (int k = 0; k < BITS_NOM; k++) begin
                hits[p] = hits[p] + CNT_W'(edges_i[p + OSR * k]);
            end
            tot[p] = cnt_q[p] + hits[p];
        end
    end

    // Dominant edge position, centre target and shortest direction.
    always_comb begin
        best       = '0;
        best_cnt   = tot[0];
        have_edges = 1'b0;
        for (int p = 0; p < OSR; p++) begin
            if (tot[p] != '0) begin
                have_edges = 1'b1;
            end
            if (tot[p] > best_cnt) begin
                best     = PH_W'(p);
                best_cnt = tot[p];
            end
        end
        target  = (int'(best) + HALF) % OSR;
        diff    = (target - int'(phase_q) + OSR) % OSR;
        move_up = have_edges && (diff != 0) && (diff <= HALF);
        move_dn = have_edges && (diff > HALF);
    end

    assign phase_inc  = (phase_q == PH_W'(OSR - 1)) ? '0 : phase_q + 1'b1;
    assign phase_dec  = (phase_q == '0) ? PH_W'(OSR - 1) : phase_q - 1'b1;
    assign snap_phase = PH_W'((int'(snap_idx_i) + HALF) % OSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            step_q  <= STEP_NONE;
            wcnt_q  <= '0;
            for (int p = 0; p < OSR; p++) begin
                cnt_q[p] <= '0;
            end
        end else if (snap_i) begin
            phase_q <= snap_phase;
            step_q  <= STEP_NONE;
            wcnt_q  <= '0;
            for (int p = 0; p < OSR; p++) begin
                cnt_q[p] <= '0;
            end
        end else if (enable_i) begin
            if (wcnt_q == WIN_W'(WINDOW - 1)) begin
                wcnt_q <= '0;
                for (int p = 0; p < OSR; p++) begin
                    cnt_q[p] <= '0;
                end
                if (move_up) begin
                    phase_q <= phase_inc;
                    step_q  <= STEP_UP;
                end else if (move_dn) begin
                    phase_q <= phase_dec;
                    step_q  <= STEP_DN;
                end else begin
                    step_q  <= STEP_NONE;
                end
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                step_q <= STEP_NONE;
                for (int p = 0; p < OSR; p++) begin
                    cnt_q[p] <= tot[p];
                end
            end
        end else begin
            step_q <= STEP_NONE;
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;

endmodule

// File: rtl/osr_bit_pick.sv
module osr_bit_pick
    import osr_pkg::*;
#(
    parameter int OSR      = 5,
    parameter int BITS_NOM = 2,
    localparam int GROUP = OSR * BITS_NOM,
    localparam int PH_W  = $clog2(OSR),
    localparam int NB_W  = $clog2(BITS_NOM + 2)
) (
    input  logic [GROUP-1:0]  samp_i,
    input  logic              prev_last_i,
    input  logic [PH_W-1:0]   phase_i,
    input  step_t             step_i,
    output logic [BITS_NOM:0] bits_o,
    output logic [NB_W-1:0]   nbits_o
);

    logic [BITS_NOM-1:0] nominal;
    logic                wrap_dn;
    logic                wrap_up;

    always_comb begin
        for (int k = 0; k < BITS_NOM; k++) begin
            nominal[k] = samp_i[int'(phase_i) + OSR * k];
        end
    end

    assign wrap_dn = (step_i == STEP_DN) && (phase_i == PH_W'(OSR - 1));
    assign wrap_up = (step_i == STEP_UP) && (phase_i == '0);

    always_comb begin
        bits_o  = '0;
        nbits_o = NB_W'(BITS_NOM);
        if (wrap_dn) begin
            // Late sample of the previous group fills the gap left by the move.
            bits_o  = {nominal, prev_last_i};
            nbits_o = NB_W'(BITS_NOM + 1);
        end else if (wrap_up) begin
            // Index 0 would repeat the bit already taken at the previous group end.
            for (int k = 1; k < BITS_NOM; k++) begin
                bits_o[k-1] = nominal[k];
            end
            nbits_o = NB_W'(BITS_NOM - 1);
        end else begin
            bits_o[BITS_NOM-1:0] = nominal;
        end
    end

endmodule

// File: rtl/osr_word_pack.sv
module osr_word_pack #(
    parameter int WORD_W = 10,
    parameter int IN_W   = 3,
    localparam int NB_W   = $clog2(IN_W + 1),
    localparam int ACC_W  = WORD_W + IN_W,
    localparam int FILL_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              enable_i,
    input  logic [IN_W-1:0]   bits_i,
    input  logic [NB_W-1:0]   nbits_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic [FILL_W-1:0] fill_o
);

    logic [ACC_W-1:0]  acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [ACC_W-1:0]  merged;
    int                total;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;

    always_comb begin
        merged = acc_q;
        for (int i = 0; i < IN_W; i++) begin
            if (i < int'(nbits_i)) begin
                merged[int'(fill_q) + i] = bits_i[i];
            end
        end
        total = int'(fill_q) + int'(nbits_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            fill_q  <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (clear_i) begin
            acc_q   <= '0;
            fill_q  <= '0;
            valid_q <= 1'b0;
        end else if (enable_i) begin
            if (total >= WORD_W) begin
                word_q  <= merged[WORD_W-1:0];
                valid_q <= 1'b1;
                acc_q   <= merged >> WORD_W;
                fill_q  <= FILL_W'(total - WORD_W);
            end else begin
                acc_q   <= merged;
                fill_q  <= FILL_W'(total);
                valid_q <= 1'b0;
            end
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;
    assign fill_o  = fill_q;

endmodule

// File: rtl/osr_bit_recovery.sv
module osr_bit_recovery
    import osr_pkg::*;
#(
    parameter int OSR      = 5,
    parameter int BITS_NOM = 2,
    parameter int WORD_W   = 10,
    parameter int WINDOW   = 16,
    localparam int GROUP  = OSR * BITS_NOM,
    localparam int IDX_W  = $clog2(GROUP),
    localparam int PH_W   = $clog2(OSR),
    localparam int IN_W   = BITS_NOM + 1,
    localparam int NB_W   = $clog2(BITS_NOM + 2),
    localparam int FILL_W = $clog2(WORD_W + IN_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUP-1:0]  line_samples_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_word_valid_o
);

    acq_state_t        state_q;
    acq_state_t        state_d;
    logic              track_en;
    logic              snap;

    logic [GROUP-1:0]  edges_w;
    logic              any_edge_w;
    logic [IDX_W-1:0]  first_idx_w;
    logic              prev_last_w;
    logic [PH_W-1:0]   phase_w;
    step_t             step_w;
    logic [IN_W-1:0]   pick_bits;
    logic [NB_W-1:0]   pick_n;
    logic [FILL_W-1:0] fill_w;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (any_edge_w) state_d = ST_ARM;
            ST_ARM:   state_d = any_edge_w ? ST_TRACK : ST_HUNT;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_HUNT;
        endcase
    end

    // Control outputs of the acquisition machine.
    always_comb begin
        track_en = 1'b0;
        snap     = 1'b0;
        unique case (state_q)
            ST_HUNT:  ;
            ST_ARM:   snap = any_edge_w;
            ST_TRACK: track_en = 1'b1;
            default:  ;
        endcase
    end

    osr_edge_detect #(
        .GROUP (GROUP)
    ) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_i      (line_samples_i),
        .edges_o     (edges_w),
        .any_edge_o  (any_edge_w),
        .first_idx_o (first_idx_w),
        .prev_last_o (prev_last_w)
    );

    osr_phase_track #(
        .OSR      (OSR),
        .BITS_NOM (BITS_NOM),
        .WINDOW   (WINDOW)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (track_en),
        .snap_i     (snap),
        .snap_idx_i (first_idx_w),
        .edges_i    (edges_w),
        .phase_o    (phase_w),
        .step_o     (step_w)
    );

    osr_bit_pick #(
        .OSR      (OSR),
        .BITS_NOM (BITS_NOM)
    ) u_pick (
        .samp_i      (line_samples_i),
        .prev_last_i (prev_last_w),
        .phase_i     (phase_w),
        .step_i      (step_w),
        .bits_o      (pick_bits),
        .nbits_o     (pick_n)
    );

    osr_word_pack #(
        .WORD_W (WORD_W),
        .IN_W   (IN_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (snap),
        .enable_i (track_en),
        .bits_i   (pick_bits),
        .nbits_i  (pick_n),
        .word_o   (rx_word_o),
        .valid_o  (rx_word_valid_o),
        .fill_o   (fill_w)
    );

endmodule

// File: rtl/osr_bit_recovery_chk.sv
module osr_bit_recovery_chk
    import osr_pkg::*;
#(
    parameter int OSR      = 5,
    parameter int BITS_NOM = 2,
    parameter int WORD_W   = 10,
    localparam int PH_W   = $clog2(OSR),
    localparam int NB_W   = $clog2(BITS_NOM + 2),
    localparam int FILL_W = $clog2(WORD_W + BITS_NOM + 2),
    localparam int GAP_MIN = (WORD_W - BITS_NOM) / BITS_NOM - 1,
    localparam int GAP_MAX = WORD_W / BITS_NOM
) (
    input logic              clk,
    input logic              rst_n,
    input acq_state_t        state,
    input logic [PH_W-1:0]   phase,
    input logic [NB_W-1:0]   nbits,
    input logic [FILL_W-1:0] fill,
    input logic              word_valid
);

    logic [3:0] gap_q;
    logic       seen_q;

    // Idle cycles since the last word pulse, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (state != ST_TRACK) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (word_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 4'hF) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    AST_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_TRACK) |-> !word_valid); // R2

    AST_PHASE_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && $past(state) == ST_TRACK) |->
            (phase == $past(phase)) ||
            (phase == (($past(phase) == PH_W'(OSR - 1)) ? '0 : $past(phase) + 1'b1)) ||
            (phase == (($past(phase) == '0) ? PH_W'(OSR - 1) : $past(phase) - 1'b1))); // R5

    AST_EXTRA_BIT_ON_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (nbits == NB_W'(BITS_NOM + 1)) |->
            (phase == PH_W'(OSR - 1)) && ($past(phase) == '0)); // R6

    AST_SKIP_BIT_ON_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (nbits == NB_W'(BITS_NOM - 1)) |->
            (phase == '0) && ($past(phase) == PH_W'(OSR - 1))); // R6

    AST_FILL_BELOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        fill < FILL_W'(WORD_W)); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R7

    AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && seen_q && state == ST_TRACK) |->
            (int'(gap_q) >= GAP_MIN) && (int'(gap_q) <= GAP_MAX)); // R9

endmodule

bind osr_bit_recovery osr_bit_recovery_chk #(
    .OSR      (OSR),
    .BITS_NOM (BITS_NOM),
    .WORD_W   (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .phase      (phase_w),
    .nbits      (pick_n),
    .fill       (fill_w),
    .word_valid (rx_word_valid_o)
);

// File: tb/osr_bit_recovery_bench.sv
`timescale 1ns/1ps
module osr_bit_recovery_bench;

    localparam int  GRP    = 10;
    localparam longint Q   = 10000;   // ticks per sample
    localparam int  JIT    = 4000;    // +/- 0.4 sample
    localparam int  RUN_CYC = 6000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [GRP-1:0] samp = '0;
    logic [9:0]     word;
    logic           valid;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    osr_bit_recovery u_osr_bit_recovery (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_samples_i  (samp),
        .rx_word_o       (word),
        .rx_word_valid_o (valid)
    );

    // Line model state
    longint     n_tick;
    longint     base_edge;
    longint     next_edge;
    longint     period;
    logic [14:0] gen_q;
    bit         cur_bit;

    // Stream checker state
    logic [14:0] hist;
    int          seeded;
    int          bit_errs;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [GRP-1:0] g);
        samp = g;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        samp  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic prbs_step(output bit b);
        b     = gen_q[14] ^ gen_q[13];
        gen_q = {gen_q[13:0], b};
    endtask

    task automatic new_edge();
        longint j;
        j = longint'($urandom_range(0, 2 * JIT)) - JIT;
        next_edge = base_edge + j;
    endtask

    task automatic make_group(output logic [GRP-1:0] g);
        for (int i = 0; i < GRP; i++) begin
            while (n_tick >= next_edge) begin
                prbs_step(cur_bit);
                base_edge = base_edge + period;
                new_edge();
            end
            g[i]   = cur_bit;
            n_tick = n_tick + Q;
        end
    endtask

    task automatic feed_bit(input bit b);
        if (seeded < 15) begin
            seeded++;
        end else if ((hist[13] ^ hist[14]) != b) begin
            bit_errs++;
        end
        hist = {hist[13:0], b};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hits;
        void'($urandom(7));

        // R1: reset values
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        check(word == 10'd0, "R1 word in reset", word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1 valid after reset", valid, 0);

        // R2: quiet line, then a lone edge group, must never produce a word
        hits = 0;
        for (int c = 0; c < 20; c++) begin
            drive(10'h000);
            hits += int'(valid);
        end
        drive(10'h01F);
        hits += int'(valid);
        for (int c = 0; c < 20; c++) begin
            drive(10'h000);
            hits += int'(valid);
        end
        check(hits == 0, "R2 no word without two edge groups", hits, 0);

        // R3 R4 R7: lock on every edge index, then a marker at the chosen phase
        for (int e = 0; e < GRP; e++) begin
            int tgt;
            int early;
            logic [GRP-1:0] lock_grp;
            tgt   = (e + 2) % 5;
            lock_grp = GRP'((10'h3FF << e) & 10'h3FF);
            do_reset();
            drive(10'h000);
            drive(10'h01F);
            drive(lock_grp);
            early = 0;
            for (int c = 0; c < 5; c++) begin
                drive(GRP'(1) << tgt);
                if (c < 4) early += int'(valid);
            end
            check(early == 0, $sformatf("R7 no early word e=%0d", e), early, 0);
            check(valid == 1'b1, $sformatf("R3 R4 word after lock e=%0d", e), valid, 1);
            check(word == 10'h155, $sformatf("R4 R7 phase/order e=%0d", e), word, 10'h155);
        end

        // R6 R8 R9: long runs with rate offset and jitter, several start phases
        for (int oi = 0; oi < 3; oi++) begin
            for (int s = 0; s < 5; s++) begin
                logic [GRP-1:0] g;
                int  words;
                int  gap_bad;
                int  last_cyc;
                bit  have_prev;
                period   = 50000 + (oi - 1) * 10;
                n_tick   = 0;
                base_edge = longint'(s) * Q + 3700;
                gen_q    = 15'h5A3C;
                prbs_step(cur_bit);
                new_edge();
                hist     = '0;
                seeded   = 0;
                bit_errs = 0;
                words    = 0;
                gap_bad  = 0;
                last_cyc = 0;
                have_prev = 1'b0;
                do_reset();
                for (int c = 0; c < RUN_CYC; c++) begin
                    make_group(g);
                    drive(g);
                    if (valid) begin
                        for (int b = 0; b < 10; b++) feed_bit(word[b]);
                        if (have_prev && ((c - last_cyc) < 4 || (c - last_cyc) > 6)) gap_bad++;
                        have_prev = 1'b1;
                        last_cyc  = c;
                        words++;
                    end
                end
                check(bit_errs == 0, $sformatf("R6 R8 stream errors off=%0d s=%0d", oi, s), bit_errs, 0);
                check(words >= RUN_CYC / 5 - 20, $sformatf("R8 word count off=%0d s=%0d", oi, s), words, RUN_CYC / 5);
                check(gap_bad == 0, $sformatf("R9 word spacing off=%0d s=%0d", oi, s), gap_bad, 0);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule